// File: doc/BRIEF.md
# Padded-Frame Serial Audio Transmitter

This block is a clock-and-frame master that turns parallel stereo samples into a three-wire serial audio stream. It generates a free-running bit clock by dividing the system clock. It also drives a word-select line that marks the channel and a serial data line. A single-entry holding register with a ready/valid handshake accepts the next stereo pair. Each frame begins with the right channel, sent while word select is high, followed by the left channel, sent while word select is low.

Two framing modes are available. In the even mode every frame is exactly two 16-bit slots long. In the stretched mode the low phase of word select is extended past the left channel by a number of idle bit clocks taken from an input. The bit clock can then run faster than 32 times the frame rate while the frame period stays exact. The serial data line sits at 0 during the idle clocks. If no new pair has arrived when a frame begins, the block sends the last pair again.

Top module: `i2stx_padded_tx`

## Requirements
- R1: While `rst_n` is low, `ws` and `sd` are 0, `bclk` is 1 and `in_ready` is 1. After reset, the first frame starts at the first falling edge of `bclk`. Until a pair is accepted, that frame carries zero samples.
- R2: `bclk` toggles every `DIV_HALF` system clocks, so its period is 2*`DIV_HALF` system clocks. It keeps running in every slot, including idle clocks.
- R3: `ws` and `sd` change only together with a falling edge of `bclk`. A receiver can therefore sample them on the rising edge.
- R4: Each frame opens with the right slot. During that slot `ws` is 1 for exactly 16 bit clocks, and `sd` carries the right sample, MSB first.
- R5: The left slot follows the right slot. `ws` is 0 and `sd` carries the 16 bits of the left sample, MSB first.
- R6: With `acc_mode` = 0 the frame is 32 bit clocks long and `pad_len` has no effect.
- R7: With `acc_mode` = 1, `pad_len` idle bit clocks follow the left slot. During these clocks `ws` is 0 and `sd` is 0. A `pad_len` of 0 gives the same frame as `acc_mode` = 0.
- R8: `in_ready` is 1 while the holding register is empty. A pair accepted while `in_valid` and `in_ready` are both 1 makes `in_ready` 0 on the next cycle. That pair is sent in the next frame, and `in_ready` returns to 1 when that frame starts.
- R9: If the holding register is empty when a frame starts, the frame repeats the previously sent pair.
- R10: `acc_mode` and `pad_len` are sampled only when the first right-slot bit is launched. A change during a frame affects only the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_mode | input | 1 | 1 selects stretched frames with idle clocks |
| pad_len | input | PAD_W | Number of idle bit clocks after the left slot |
| in_valid | input | 1 | Stereo pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| bclk | output | 1 | Continuous bit clock |
| ws | output | 1 | Word select, 1 during the right slot |
| sd | output | 1 | Serial data, MSB first |

## Verification
The first frames use even mode, and one of them drives a nonzero `pad_len` to show that the count is ignored. Stretched frames follow with 5, 0 and the maximum of 63 idle clocks. These separate a correct pad length from off-by-one and stuck-at-zero errors, and they show that a zero count matches even mode. Two frames leave the holding register empty to confirm that the previous pair is repeated under both modes. One frame changes the mode while a stretched frame is in progress, which shows that framing is sampled only at the start of a frame. The sample values mix asymmetric bit patterns, so a swapped channel or a reversed bit order appears as a data mismatch.

// File: rtl/i2stx_pkg.sv
// Shared types for the padded-frame serial audio transmitter.
package i2stx_pkg;
    // Slot currently being launched on the serial line.
    typedef enum logic [1:0] {
        SLOT_RIGHT = 2'd0,
        SLOT_LEFT  = 2'd1,
        SLOT_PAD   = 2'd2
    } slot_e;
endpackage

// File: rtl/i2stx_bclk_gen.sv
// Bit-clock divider. It toggles bclk every DIV_HALF system clocks and
// raises fall_stb in the cycle whose edge takes bclk from 1 to 0.
// Assumes DIV_HALF >= 1. bclk idles high in reset, so the first edge
// after reset is a falling edge.
module i2stx_bclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic fall_stb
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DW-1:0] div_q;
    logic          bclk_q;
    logic          tick;

    // Half-period reached.
    assign tick     = (div_q == DW'(DIV_HALF - 1));
    assign fall_stb = tick & bclk_q;
    assign bclk     = bclk_q;

    // Count the half period and toggle the clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            bclk_q <= 1'b1;
        end else if (tick) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            div_q  <= div_q + DW'(1);
        end
    end

    p_fall_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !bclk_q);
    p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DW'(DIV_HALF - 1));
endmodule

// File: rtl/i2stx_slot_seq.sv
// Frame sequencer. It walks through the right slot, the left slot and
// the optional idle slot, one position per bclk falling edge. It drives
// ws and samples the framing controls at the first right bit.
// Assumes SAMPLE_W is a power of two.
module i2stx_slot_seq
    import i2stx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int PAD_W    = 6,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_stb,
    input  logic             acc_mode,
    input  logic [PAD_W-1:0] pad_len,
    output slot_e            slot,
    output logic [IDX_W-1:0] idx,
    output logic             frame_start,
    output logic             ws
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SAMPLE_W - 1);

    slot_e            slot_q, slot_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [PAD_W-1:0] pad_q, pad_d;
    logic             ws_q;

    assign slot        = slot_q;
    assign idx         = idx_q;
    assign ws          = ws_q;
    assign frame_start = fall_stb && (slot_q == SLOT_RIGHT) && (idx_q == '0);

    // Next position in the frame and pad length latched at frame start.
    always_comb begin
        slot_d = slot_q;
        idx_d  = idx_q + IDX_W'(1);
        pad_d  = pad_q;
        if (frame_start) pad_d = acc_mode ? pad_len : '0;
        unique case (slot_q)
            SLOT_RIGHT: if (idx_q == LAST) begin
                slot_d = SLOT_LEFT;
                idx_d  = '0;
            end
            SLOT_LEFT: if (idx_q == LAST) begin
                slot_d = (pad_d == '0) ? SLOT_RIGHT : SLOT_PAD;
                idx_d  = '0;
            end
            SLOT_PAD: if (idx_q == IDX_W'(pad_q) - IDX_W'(1)) begin
                slot_d = SLOT_RIGHT;
                idx_d  = '0;
            end
            default: begin
                slot_d = SLOT_RIGHT;
                idx_d  = '0;
            end
        endcase
    end

    // Advance on each falling edge; ws follows the launched slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_RIGHT;
            idx_q  <= '0;
            pad_q  <= '0;
            ws_q   <= 1'b0;
        end else if (fall_stb) begin
            slot_q <= slot_d;
            idx_q  <= idx_d;
            pad_q  <= pad_d;
            ws_q   <= (slot_q == SLOT_RIGHT);
        end
    end

    p_ws_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && slot_q == SLOT_RIGHT) |=> ws_q);
    p_ws_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(ws_q));
    p_pad_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_PAD) |-> (pad_q != '0));
endmodule

// File: rtl/i2stx_sample_path.sv
// Sample path. It holds one offered stereo pair, moves it into the
// current pair at frame start (or keeps the old pair on underrun), and
// launches one data bit per falling edge, MSB first, with 0 in idle slots.
// Assumes SAMPLE_W is a power of two.
module i2stx_sample_path
    import i2stx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_stb,
    input  logic                frame_start,
    input  slot_e               slot,
    input  logic [IDX_W-1:0]    idx,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output logic                sd
);
    localparam int BW = $clog2(SAMPLE_W);

    logic                pend_full;
    logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, src_r;
    logic                take, accept, sd_q, sd_d;
    logic [BW-1:0]       bsel;

    assign in_ready = !pend_full;
    assign accept   = in_valid && !pend_full;
    assign take     = frame_start && pend_full;
    assign src_r    = take ? pend_r : cur_r;
    assign bsel     = BW'(SAMPLE_W - 1) - idx[BW-1:0];
    assign sd       = sd_q;

    // Bit to launch for the current slot position.
    always_comb begin
        unique case (slot)
            SLOT_RIGHT: sd_d = src_r[bsel];
            SLOT_LEFT:  sd_d = cur_l[bsel];
            default:    sd_d = 1'b0;
        endcase
    end

    // Holding register fill and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_l    <= '0;
            pend_r    <= '0;
        end else if (accept) begin
            pend_full <= 1'b1;
            pend_l    <= in_left;
            pend_r    <= in_right;
        end else if (take) begin
            pend_full <= 1'b0;
        end
    end

    // Current pair, replaced only when a fresh pair is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_l <= '0;
            cur_r <= '0;
        end else if (take) begin
            cur_l <= pend_l;
            cur_r <= pend_r;
        end
    end

    // Serial data register, updated on falling edges only.
    always_ff @(posedge clk) begin
        if (!rst_n)        sd_q <= 1'b0;
        else if (fall_stb) sd_q <= sd_d;
    end

    p_hold_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    p_take_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> in_ready);
    p_sd_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(sd_q));
    p_pad_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && slot == SLOT_PAD) |=> !sd_q);
    p_idx_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SLOT_PAD) |-> (idx < IDX_W'(SAMPLE_W)));
endmodule

// File: rtl/i2stx_padded_tx.sv
// Top level of the padded-frame serial audio transmitter. It connects
// the bit-clock divider, the frame sequencer and the sample path.
// The block is always clock and frame master.
module i2stx_padded_tx
    import i2stx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int PAD_W    = 6,
    parameter int DIV_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_mode,
    input  logic [PAD_W-1:0]    pad_len,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                bclk,
    output logic                ws,
    output logic                sd
);
    localparam int BW    = $clog2(SAMPLE_W);
    localparam int IDX_W = (PAD_W > BW) ? PAD_W : BW;

    logic             fall_stb, frame_start;
    slot_e            slot;
    logic [IDX_W-1:0] idx;

    i2stx_bclk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fall_stb(fall_stb)
    );

    i2stx_slot_seq #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .acc_mode(acc_mode),
        .pad_len(pad_len), .slot(slot), .idx(idx),
        .frame_start(frame_start), .ws(ws)
    );

    i2stx_sample_path #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_data (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb),
        .frame_start(frame_start), .slot(slot), .idx(idx),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .in_ready(in_ready), .sd(sd)
    );
endmodule

// File: tb/i2stx_padded_tx_bench.sv
// Scoreboard bench: driver tasks queue the expected (ws, sd) bits of each
// frame, and a monitor compares them at every rising bclk edge.
`timescale 1ns/1ps
module i2stx_padded_tx_bench;
    localparam int SW = 16;
    localparam int PW = 6;
    localparam int DH = 2;

    typedef struct {
        logic  ws;
        logic  sd;
        string tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_mode = 1'b0;
    logic [PW-1:0] pad_len = '0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_left = '0, in_right = '0;
    logic          in_ready, bclk, ws, sd;

    item_t         exp_q[$];
    int            n_checks = 0, n_fail = 0;
    bit            mon_en = 1'b0, done = 1'b0;
    logic [SW-1:0] last_l = '0, last_r = '0;

    always #2.5 clk = ~clk;

    i2stx_padded_tx #(.SAMPLE_W(SW), .PAD_W(PW), .DIV_HALF(DH)) u_i2stx_padded_tx (
        .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .pad_len(pad_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
        .in_right(in_right), .bclk(bclk), .ws(ws), .sd(sd)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Queue the expected bits of one frame.
    task automatic push_frame(input logic [SW-1:0] l, input logic [SW-1:0] r,
                              input logic acc, input int pad, input string tag);
        for (int i = SW - 1; i >= 0; i--) exp_q.push_back('{1'b1, r[i], tag});
        for (int i = SW - 1; i >= 0; i--) exp_q.push_back('{1'b0, l[i], tag});
        if (acc) for (int i = 0; i < pad; i++) exp_q.push_back('{1'b0, 1'b0, tag});
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!in_ready);
    endtask

    // Offer a pair, with the framing it will be sent under.
    task automatic send(input logic acc, input int pad, input logic [SW-1:0] l,
                        input logic [SW-1:0] r, input string tag);
        wait_ready();
        acc_mode = acc;
        pad_len  = PW'(pad);
        in_left  = l;
        in_right = r;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R8", "in_ready after accept", in_ready, 0);
        push_frame(l, r, acc, pad, tag);
        last_l = l;
        last_r = r;
    endtask

    // Offer nothing for one frame: the last pair must repeat.
    task automatic starve(input logic acc, input int pad, input string tag);
        wait_ready();
        acc_mode = acc;
        pad_len  = PW'(pad);
        while (ws) @(negedge clk);
        while (!ws) @(negedge clk);
        push_frame(last_l, last_r, acc, pad, tag);
    endtask

    // Monitor: pops and compares at rising bclk, checks period and edges.
    logic bclk_p = 1'b1, ws_p = 1'b0, sd_p = 1'b0;
    int   since_rise = 0;
    bit   seen_rise = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            since_rise++;
            if ((ws !== ws_p) || (sd !== sd_p))
                check(!bclk && bclk_p, "R3", "ws/sd change without bclk fall", 1, 0);
            if (bclk && !bclk_p) begin
                if (seen_rise)
                    check(since_rise == 2 * DH, "R2", "bclk period", since_rise, 2 * DH);
                seen_rise  = 1'b1;
                since_rise = 0;
                if (exp_q.size() > 0) begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(ws === e.ws, e.tag, "ws", ws, e.ws);
                    check(sd === e.sd, e.tag, "sd", sd, e.sd);
                end
            end
        end
        bclk_p = bclk;
        ws_p   = ws;
        sd_p   = sd;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ws == 1'b0, "R1", "ws in reset", ws, 0);
        check(sd == 1'b0, "R1", "sd in reset", sd, 0);
        check(bclk == 1'b1, "R1", "bclk in reset", bclk, 1);
        check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        push_frame('0, '0, 1'b0, 0, "R1");
        rst_n = 1'b1;
        mon_en = 1'b1;
        while (!ws) @(negedge clk);
        send(1'b0, 0,  16'h1234, 16'hF00D, "R4/R5");
        send(1'b0, 37, 16'h8001, 16'h7FFE, "R6");
        send(1'b1, 5,  16'hA5C3, 16'h3C5A, "R7");
        send(1'b1, 0,  16'h0F0F, 16'hE001, "R7");
        send(1'b1, 63, 16'hFFFF, 16'h0000, "R7");
        send(1'b0, 12, 16'h4C2D, 16'hB3D2, "R10");
        starve(1'b1, 3, "R9");
        starve(1'b0, 9, "R9");
        send(1'b1, 1,  16'h0001, 16'h8000, "R7");
        send(1'b0, 0,  16'hC0DE, 16'hBEEF, "R4/R5");
        while (exp_q.size() > 0) @(negedge clk);
        mon_en = 1'b0;
        done   = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", exp_q.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule